// File: doc/BRIEF.md
# Two-Line Edge-Triggered Interrupt Source Bank

This block collects up to 32 single-bit event sources (20 by default) into latched status bits. It drives two independent interrupt request lines, so two separate host agents can each service their own view of the same events. Each raw source is first brought into the clock domain. It is then compared against its previous sample, and a per-source 2-bit edge selection decides whether a rising edge, a falling edge, both or neither count as an event.

The edge selection is shared by both lines. Each line has its own status and its own mask, and raises its request when any unmasked status bit is set. A control bit selects how status is cleared. In one mode, reading a status byte clears the bits it returned. In the other, software writes ones to the bits it wants to clear. An event that arrives while its status bit is still set is held pending, and it sets the bit again once the clear takes effect.

All registers are one byte wide and sit behind a simple synchronous port with address, write data, write strobe, read strobe and registered read data. Multi-byte fields are little-endian: byte k holds bits 8k to 8k+7.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, every edge-select bit is 0, the clear mode bit is 0 and both irq_o bits are 0.
- R2: Source i is configured by bits (i mod 4)*2+1 (rising enable) and (i mod 4)*2 (falling enable) of edge byte i/4. An enabled transition of the source sets the status bit of source i on both lines.
- R3: A source whose two edge-select bits are both 0 never sets status on either line, whatever its input does.
- R4: The two lines keep separate status and mask bits. Clearing status or writing the mask on one line leaves the other line unchanged, and a mask bit of 1 keeps that source off the line's request.
- R5: irq_o[l] is 1 exactly one clock after the status of line l ANDed with the inverse of its mask becomes nonzero, and it returns to 0 one clock after that AND becomes zero.
- R6: With the clear mode bit (bit 0 of the control byte) set to 1, a read of a status byte returns the byte and clears the bits it returned. Writes to status bytes then have no effect.
- R7: With the clear mode bit set to 0, a read leaves status unchanged. Writing a 1 to a status bit clears it, and writing 0 has no effect.
- R8: An enabled event on a source whose status bit is already set is held pending. The next clear leaves the bit at 1, and a second clear is needed to bring it to 0.
- R9: If an event and a clear reach the same status bit in the same clock, the bit stays 1 and nothing is left pending, so one further clear brings it to 0.
- R10: Address map: control at 0x00, edge byte k at 0x08+k, line 0 status byte k at 0x10+k, line 0 mask byte k at 0x14+k, line 1 status at 0x18+k, line 1 mask at 0x1C+k. rdata_o is valid on the clock after rd_en_i. Status bits at or above the source count read 0 and mask bits there read 1. Unmapped addresses and idle cycles return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Raw asynchronous event inputs |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 2 | Interrupt request, one bit per line |

## Verification
A raw input change applied before clock edge k passes through two synchroniser flops. The change is seen as an event in the cycle after edge k+1, lands in status at edge k+2 and appears on irq_o after edge k+3. The bench therefore waits six clocks after every source change before it compares irq_o or reads status. Read data is registered on the clock that samples rd_en_i, so the bench takes it at the following falling edge. The same-cycle collision of R9 is set up by counting exactly two falling edges after the source change, so that the clear write is sampled at edge k+2.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int ADDR_W    = 5;
  localparam int NUM_LINES = 2;
  localparam int A_CTRL    = 'h00;
  localparam int A_EDGE    = 'h08;
  localparam int A_STAT    = 'h10;
  localparam int A_MASK    = 'h14;
  localparam int LINE_STEP = 'h08;

  function automatic int bytes_for(input int nbits);
    return (nbits + 7) / 8;
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NUM_SRC = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] rise_en_i,
  input  logic [NUM_SRC-1:0] fall_en_i,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign evt_o[i] = (rise_en_i[i] &  sync_q[i] & ~prev_q[i]) |
                      (fall_en_i[i] & ~sync_q[i] &  prev_q[i]);
  end
endmodule

// File: rtl/irq_line_status.sv
module irq_line_status #(
  parameter int NUM_SRC = 20,
  parameter int NB      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               cor_i,
  input  logic [NB-1:0]      st_rd_i,
  input  logic [NB-1:0]      st_wr_i,
  input  logic [NB-1:0]      mk_wr_i,
  input  logic [7:0]         wdata_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] st_q, pend_q, mk_q, clr_v, st_d, pend_d;
  logic               irq_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    localparam int BY = i / 8;
    localparam int BI = i % 8;
    assign clr_v[i] = cor_i ? (st_rd_i[BY] & st_q[i]) : (st_wr_i[BY] & wdata_i[BI]);
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (clr_v[i]) begin
        if (evt_i[i]) begin
          st_d[i] = 1'b1;
        end else begin
          st_d[i]   = pend_q[i];
          pend_d[i] = 1'b0;
        end
      end else if (evt_i[i]) begin
        if (st_q[i]) pend_d[i] = 1'b1;
        else         st_d[i]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      pend_q <= '0;
      mk_q   <= '1;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (mk_wr_i[i/8]) mk_q[i] <= wdata_i[i%8];
      end
      irq_q  <= |(st_q & ~mk_q);
    end
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;
  assign irq_o    = irq_q;

  // R4: a fully masked line never requests on the next clock
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (&mk_q) |=> !irq_o);

  // R3: a status bit rises only from an event or a pending entry
  p_set_needs_event_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(evt_i | pend_q)) == '0));

  // R8: a cleared bit with a pending entry comes straight back
  p_pend_reassert_r8: assert property (@(posedge clk) disable iff (rst)
    (|(clr_v & pend_q)) |=> ((st_q & $past(clr_v & pend_q)) == $past(clr_v & pend_q)));

  // R6: clear-on-read drops returned bits that had no event or pending entry
  p_cor_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (cor_i && |st_rd_i) |=> ((st_q & $past(clr_v) & ~$past(evt_i) & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [4:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [7:0]         rdata_o,
  output logic [1:0]         irq_o
);
  localparam int NB = bytes_for(NUM_SRC);
  localparam int EB = bytes_for(2 * NUM_SRC);

  logic              cor_q;
  logic [EB*8-1:0]   edge_q;
  logic [NUM_SRC-1:0] rise_en, fall_en, evt;
  logic [NUM_SRC-1:0] status [NUM_LINES];
  logic [NUM_SRC-1:0] mask   [NUM_LINES];
  logic [NB*8-1:0]   st_pad [NUM_LINES];
  logic [NB*8-1:0]   mk_pad [NUM_LINES];
  logic [NB-1:0]     st_rd  [NUM_LINES];
  logic [NB-1:0]     st_wr  [NUM_LINES];
  logic [NB-1:0]     mk_wr  [NUM_LINES];
  logic [7:0]        rd_mux, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cor_q  <= 1'b0;
      edge_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(A_CTRL)) cor_q <= wdata_i[0];
      for (int b = 0; b < EB; b++) begin
        if (addr_i == ADDR_W'(A_EDGE + b)) edge_q[b*8 +: 8] <= wdata_i;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
    assign rise_en[i] = edge_q[2*i+1];
    assign fall_en[i] = edge_q[2*i];
  end

  irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .evt_o     (evt)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar b = 0; b < NB; b++) begin : g_dec
      assign st_rd[l][b] = rd_en_i && (addr_i == ADDR_W'(A_STAT + l*LINE_STEP + b));
      assign st_wr[l][b] = wr_en_i && (addr_i == ADDR_W'(A_STAT + l*LINE_STEP + b));
      assign mk_wr[l][b] = wr_en_i && (addr_i == ADDR_W'(A_MASK + l*LINE_STEP + b));
    end

    irq_line_status #(.NUM_SRC(NUM_SRC), .NB(NB)) u_line (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt),
      .cor_i    (cor_q),
      .st_rd_i  (st_rd[l]),
      .st_wr_i  (st_wr[l]),
      .mk_wr_i  (mk_wr[l]),
      .wdata_i  (wdata_i),
      .status_o (status[l]),
      .mask_o   (mask[l]),
      .irq_o    (irq_o[l])
    );

    always_comb begin
      st_pad[l] = '0;
      st_pad[l][NUM_SRC-1:0] = status[l];
      mk_pad[l] = '1;
      mk_pad[l][NUM_SRC-1:0] = mask[l];
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr_i == ADDR_W'(A_CTRL)) rd_mux = {7'd0, cor_q};
    for (int b = 0; b < EB; b++) begin
      if (addr_i == ADDR_W'(A_EDGE + b)) rd_mux = edge_q[b*8 +: 8];
    end
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(A_STAT + l*LINE_STEP + b)) rd_mux = st_pad[l][b*8 +: 8];
        if (addr_i == ADDR_W'(A_MASK + l*LINE_STEP + b)) rd_mux = mk_pad[l][b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else     rdata_q <= rd_en_i ? rd_mux : 8'h00;
  end

  assign rdata_o = rdata_q;

  // R10: no read strobe means zero read data on the next clock
  p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rdata_o == 8'h00));
endmodule

// File: tb/irq_src_bank_bench.sv
module irq_src_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 20;
  localparam int NB = 3;
  localparam int EB = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] src;
  logic [4:0]   addr;
  logic [7:0]   wdata;
  logic         wr_en, rd_en;
  logic [7:0]   rdata;
  logic [1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_bank #(.NUM_SRC(N)) u_irq_src_bank (
    .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_status(input int line, output logic [23:0] v);
    logic [7:0] b;
    for (int k = 0; k < NB; k++) begin
      rd(5'(8'h10 + line*8 + k), b);
      v[k*8 +: 8] = b;
    end
  endtask

  task automatic clear_all();
    for (int l = 0; l < 2; l++)
      for (int k = 0; k < NB; k++) wr(5'(8'h10 + l*8 + k), 8'hFF);
  endtask

  task automatic set_edges(input logic [39:0] e);
    for (int k = 0; k < EB; k++) wr(5'(8'h08 + k), e[k*8 +: 8]);
  endtask

  task automatic set_mask(input int line, input logic [23:0] m);
    for (int k = 0; k < NB; k++) wr(5'(8'h14 + line*8 + k), m[k*8 +: 8]);
  endtask

  function automatic logic [N-1:0] exp_evt(input logic [N-1:0] o, input logic [N-1:0] n,
                                           input logic [39:0] e);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = (o[i] != n[i]) && ((n[i] && e[2*i+1]) || (!n[i] && e[2*i]));
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]   d;
    logic [23:0]  v;
    logic [39:0]  e;
    logic [23:0]  m0, m1;
    logic [N-1:0] nsrc, ex;
    void'($urandom(32'd7341));
    rst = 1'b1; src = '0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // R1: reset state
    check("R1 irq", 32'(irq), 32'h0);
    rd(5'h00, d); check("R1 ctrl", 32'(d), 32'h0);
    rd(5'h08, d); check("R1 edge", 32'(d), 32'h0);
    rd(5'h14, d); check("R1 mask0", 32'(d), 32'hFF);
    rd(5'h1E, d); check("R1 mask1", 32'(d), 32'hFF);
    rd_status(0, v); check("R1 status0", 32'(v), 32'h0);

    // R3: edge fields all zero, every source toggles, nothing latched
    src = '1; wait_n(6);
    rd_status(0, v); check("R3 no edge line0", 32'(v), 32'h0);
    rd_status(1, v); check("R3 no edge line1", 32'(v), 32'h0);
    src = '0; wait_n(6);

    // R2 R4 R5: random edge config, masks and input patterns
    for (int it = 0; it < 24; it++) begin
      e  = {$urandom, $urandom};
      e[39:0] = e[39:0];
      m0 = 24'($urandom) & 24'h0FFFFF;
      m1 = 24'($urandom) & 24'h0FFFFF;
      if (it == 0) e = '0;
      set_edges(e);
      set_mask(0, m0);
      set_mask(1, m1);
      nsrc = N'($urandom);
      ex = exp_evt(src, nsrc, e);
      src = nsrc;
      wait_n(6);
      check("R5 irq0", 32'(irq[0]), 32'(|(ex & ~m0[N-1:0])));
      check("R5 irq1", 32'(irq[1]), 32'(|(ex & ~m1[N-1:0])));
      rd_status(0, v); check("R2 status0", 32'(v), 32'(ex));
      rd_status(1, v); check("R2 status1", 32'(v), 32'(ex));
      clear_all();
      wait_n(2);
      check("R5 irq after clear", 32'(irq), 32'h0);
    end

    set_edges('0);
    src = '0; wait_n(6);
    clear_all();

    // R7: write-one-to-clear mode
    set_edges(40'h02);
    set_mask(0, 24'hFFFFFE);
    set_mask(1, 24'hFFFFFF);
    src[0] = 1'b1; wait_n(6);
    check("R5 irq unmasked line", 32'(irq), 32'h1);
    rd(5'h10, d); check("R7 first read", 32'(d), 32'h01);
    rd(5'h10, d); check("R7 read keeps", 32'(d), 32'h01);
    wr(5'h10, 8'h00);
    rd(5'h10, d); check("R7 zero write", 32'(d), 32'h01);
    wr(5'h10, 8'h01);
    rd(5'h10, d); check("R7 one clears", 32'(d), 32'h00);
    rd(5'h18, d); check("R4 line1 kept", 32'(d), 32'h01);
    check("R5 irq drop", 32'(irq), 32'h0);
    wr(5'h18, 8'h01);
    src[0] = 1'b0; wait_n(6);
    rd(5'h10, d); check("R2 falling disabled", 32'(d), 32'h00);

    // R6: clear-on-read mode
    wr(5'h00, 8'h01);
    rd(5'h00, d); check("R6 ctrl", 32'(d), 32'h01);
    src[0] = 1'b1; wait_n(6);
    wr(5'h18, 8'hFF);
    rd(5'h10, d); check("R6 read returns", 32'(d), 32'h01);
    rd(5'h10, d); check("R6 read cleared", 32'(d), 32'h00);
    rd(5'h18, d); check("R6 write ignored", 32'(d), 32'h01);
    rd(5'h18, d); check("R6 line1 cleared", 32'(d), 32'h00);
    wr(5'h00, 8'h00);
    src[0] = 1'b0; wait_n(6);

    // R8: second event held pending
    src[0] = 1'b1; wait_n(6);
    src[0] = 1'b0; wait_n(6);
    src[0] = 1'b1; wait_n(6);
    rd(5'h10, d); check("R8 set", 32'(d), 32'h01);
    wr(5'h10, 8'h01);
    rd(5'h10, d); check("R8 reasserted", 32'(d), 32'h01);
    wr(5'h10, 8'h01);
    rd(5'h10, d); check("R8 drained", 32'(d), 32'h00);
    clear_all(); clear_all();
    src[0] = 1'b0; wait_n(6);

    // R9: event and clear in the same clock
    set_edges(40'h08);
    src[1] = 1'b1; wait_n(6);
    src[1] = 1'b0; wait_n(6);
    src[1] = 1'b1;
    wait_n(2);
    wr(5'h10, 8'h02);
    rd(5'h10, d); check("R9 edge wins", 32'(d), 32'h02);
    wr(5'h10, 8'h02);
    rd(5'h10, d); check("R9 no pending", 32'(d), 32'h00);
    clear_all(); clear_all();
    src = '0; wait_n(6);
    clear_all(); clear_all();

    // R10: padding, unmapped address, edge readback
    set_edges(40'hFF_FFFF_FFFF);
    src = '1; wait_n(6);
    rd(5'h12, d); check("R10 status pad", 32'(d), 32'h0F);
    wr(5'h16, 8'h00);
    rd(5'h16, d); check("R10 mask pad", 32'(d), 32'hF0);
    rd(5'h05, d); check("R10 unmapped", 32'(d), 32'h00);
    rd(5'h0C, d); check("R10 edge readback", 32'(d), 32'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule